// File: doc/BRIEF.md
# Triggered Clock Glitch Generator

This block derives a target clock from a fast reference clock and, once armed, adds a single extra narrow pulse next to one chosen rising edge of that target clock. An external trigger starts the sequence. A configured number of target-clock rising edges is then counted, and the last of these is the targeted edge. A signed shift and a width, both in reference ticks, place the extra pulse in the low phase. A negative shift puts the pulse before the targeted edge. A positive shift puts it after the falling edge of the targeted cycle.

The target clock runs freely with a period of twice the configured half period. All pulse timing is in reference ticks. An arm request is honoured only when no event is in progress. It checks the configuration and latches delay, shift and width. If the configuration is unacceptable, the block raises an error flag and stays idle. A completion flag shows that the pulse has been emitted. It stays set until the next arm request.

Top module: `trig_glitch_gen`

## Requirements
- R1: With no pulse pending, `tgt_clk` is high for `half_period` ticks and then low for `half_period` ticks, repeating.
- R2: A trigger rising edge that arrives while the block is not armed produces no extra pulse and leaves `done` low.
- R3: With positive shift S and width W, and D the delay, the targeted edge is the D-th `tgt_clk` rising edge after the trigger edge is seen. `tgt_clk` is then additionally high for W ticks starting N+S ticks after the targeted edge, where N is `half_period`.
- R4: With negative shift S, `tgt_clk` is additionally high for W ticks starting |S| ticks before the targeted edge.
- R5: Only one pulse is emitted per arm request. Later trigger edges add no pulse and leave `done` set.
- R6: `done` rises after the pulse ends. It stays high until the next arm request, and that request clears it.
- R7: An arm request with an unacceptable configuration sets `cfg_err`, leaves the block idle with `done` low, and later trigger edges produce no pulse.
- R8: A configuration is acceptable only if all of the following hold:
  - N is at least 4;
  - W is nonzero and less than N;
  - S is nonzero;
  - D is nonzero;
  - for positive S, S+W is less than N;
  - for negative S, |S| is between W+1 and N-1, and D is at least 2.
- R9: An arm request during delay counting or pulse output is ignored. The configuration latched earlier still governs the pulse, and `cfg_err` stays unchanged.
- R10: An arm request with an acceptable configuration clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_period | input | NW | Target clock half period N in ticks |
| delay_cyc | input | DW | Targeted edge count D after the trigger |
| shift_ticks | input | NW+1 | Signed pulse shift S in ticks |
| glitch_width | input | NW | Pulse width W in ticks |
| arm | input | 1 | Arm request, honoured only when idle or done |
| trigger | input | 1 | Asynchronous trigger, rising edge used |
| tgt_clk | output | 1 | Target clock with optional extra pulse |
| done | output | 1 | Pulse has been emitted |
| cfg_err | output | 1 | Last arm request had an unacceptable configuration |

## Verification
The hardest cases to reach from the ports are the ones where the extra pulse sits right at a legal limit. Examples are a pulse ending one tick before the targeted edge, or starting one tick after the falling edge. These only appear when the trigger falls at a known point in the target cycle. The stimulus therefore waits for a rising edge of `tgt_clk` and raises the trigger a fixed two ticks later. It then records the whole waveform tick by tick and compares it with a pattern computed from N, D, S and W. An arm pulse carrying an invalid shift is injected mid-count, to show that the latched values still govern the pulse.

// File: rtl/trig_glitch_gen.sv
module trig_glitch_gen #(
  parameter int NW = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NW-1:0]        half_period,
  input  logic [DW-1:0]        delay_cyc,
  input  logic signed [NW:0]   shift_ticks,
  input  logic [NW-1:0]        glitch_width,
  input  logic                 arm,
  input  logic                 trigger,
  output logic                 tgt_clk,
  output logic                 done,
  output logic                 cfg_err
);
  localparam int PW = NW + 2;
  localparam logic [2:0] S_IDLE = 3'd0, S_ARMED = 3'd1, S_COUNT = 3'd2,
                         S_GLITCH = 3'd3, S_DONE = 3'd4;

  logic [2:0]    state;
  logic [PW-1:0] phase;
  logic [2:0]    trig_q;
  logic          neg_q;
  logic [PW-1:0] mag_q;
  logic [PW-1:0] w_q;
  logic [DW-1:0] rem;

  wire [PW-1:0] period2 = {1'b0, half_period, 1'b0};
  wire [PW-1:0] hp_x    = {2'b00, half_period};
  wire [PW-1:0] w_x     = {2'b00, glitch_width};
  wire          wrap    = (phase + 1'b1) >= period2;
  wire          base_c  = phase < hp_x;
  wire          trig_edge = trig_q[1] & ~trig_q[2];

  wire          sh_neg = shift_ticks[NW];
  wire [NW:0]   sh_u   = shift_ticks;
  wire [PW-1:0] mag    = {1'b0, sh_neg ? (~sh_u + 1'b1) : sh_u};

  wire neg_ok = (mag >= w_x + 1'b1) && (mag <= hp_x - 1'b1) && (delay_cyc >= DW'(2));
  wire pos_ok = (mag + w_x) < hp_x;
  wire cfg_ok = (hp_x >= PW'(4)) && (w_x != '0) && (w_x < hp_x) && (mag != '0) &&
                (delay_cyc != '0) && (sh_neg ? neg_ok : pos_ok);

  wire [PW-1:0] g_start = neg_q ? (period2 - mag_q) : (hp_x + mag_q);
  wire [PW-1:0] g_end   = g_start + w_q - 1'b1;
  wire          glit_c  = (state == S_GLITCH) && (phase >= g_start) && (phase <= g_end);

  assign done = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      tgt_clk <= 1'b0;
      trig_q  <= '0;
    end else begin
      phase   <= wrap ? '0 : phase + 1'b1;
      tgt_clk <= base_c | glit_c;
      trig_q  <= {trig_q[1:0], trigger};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cfg_err <= 1'b0;
      neg_q   <= 1'b0;
      mag_q   <= '0;
      w_q     <= '0;
      rem     <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (arm) begin
            if (cfg_ok) begin
              state   <= S_ARMED;
              cfg_err <= 1'b0;
              neg_q   <= sh_neg;
              mag_q   <= mag;
              w_q     <= w_x;
              rem     <= delay_cyc;
            end else begin
              state   <= S_IDLE;
              cfg_err <= 1'b1;
            end
          end
        end
        S_ARMED: if (trig_edge) state <= S_COUNT;
        S_COUNT: begin
          if (wrap) begin
            rem <= rem - 1'b1;
            if ((!neg_q && rem == DW'(1)) || (neg_q && rem == DW'(2)))
              state <= S_GLITCH;
          end
        end
        S_GLITCH: if (phase == g_end) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_glitch_gen_chk.sv
module trig_glitch_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       cfg_err,
  input logic [2:0] state,
  input logic       base_c,
  input logic       glit_c
);
  localparam logic [2:0] C_IDLE = 3'd0, C_COUNT = 3'd2, C_GLITCH = 3'd3, C_DONE = 3'd4;

  a_r3_pulse_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    glit_c |-> !base_c);

  a_r5_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glit_c) |-> state == C_DONE);

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_DONE && !arm) |=> state == C_DONE);

  a_r7_err_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> state == C_IDLE);

  a_r9_count_not_rearmed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_COUNT) |=> (state == C_COUNT || state == C_GLITCH));

  a_r9_err_kept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_COUNT || state == C_GLITCH) |=> $stable(cfg_err));
endmodule

bind trig_glitch_gen trig_glitch_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_err(cfg_err),
  .state(state), .base_c(base_c), .glit_c(glit_c)
);

// File: tb/trig_glitch_gen_bench.sv
module trig_glitch_gen_bench;
  localparam int NW = 8;
  localparam int DW = 16;
  localparam int N  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] half_period = NW'(N);
  logic [DW-1:0] delay_cyc = '0;
  logic signed [NW:0] shift_ticks = '0;
  logic [NW-1:0] glitch_width = '0;
  logic arm = 1'b0;
  logic trigger = 1'b0;
  logic tgt_clk, done, cfg_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  trig_glitch_gen #(.NW(NW), .DW(DW)) u_trig_glitch_gen (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .delay_cyc(delay_cyc),
    .shift_ticks(shift_ticks), .glitch_width(glitch_width), .arm(arm),
    .trigger(trigger), .tgt_clk(tgt_clk), .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_arm(input int n, input int d, input int s, input int w);
    @(negedge clk);
    half_period  = NW'(n);
    delay_cyc    = DW'(d);
    shift_ticks  = (NW+1)'(s);
    glitch_width = NW'(w);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic run_trace(input int d, input bit expg, input int s, input int w,
                           input int arm_idx, input string req);
    int len;
    bit tr[0:255];
    bit prev;
    bit found;
    bit eb;
    int bad;
    int lo;
    int keep;
    len = (d + 2) * 2 * N;
    bad = -1;
    keep = s;
    found = 0;
    prev = tgt_clk;
    while (!found) begin
      @(negedge clk);
      if (!prev && tgt_clk) found = 1;
      prev = tgt_clk;
    end
    tr[0] = tgt_clk;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      tr[i] = tgt_clk;
      if (i == 2) trigger = 1'b1;
      if (i == 6) trigger = 1'b0;
      if (i == arm_idx) begin arm = 1'b1; shift_ticks = '0; end
      if (arm_idx >= 0 && i == arm_idx + 1) begin arm = 1'b0; shift_ticks = (NW+1)'(keep); end
    end
    lo = (s > 0) ? d * 2 * N + N + s : d * 2 * N + s;
    for (int i = 0; i < len; i++) begin
      eb = ((i % (2 * N)) < N);
      if (expg && i >= lo && i < lo + w) eb = 1'b1;
      if (bad < 0 && tr[i] != eb) bad = i;
    end
    if (bad < 0) check(1'b1, req, "waveform", 0, 0);
    else check(1'b0, req, $sformatf("waveform tick %0d", bad), int'(tr[bad]),
               int'(!tr[bad]));
  endtask

  task automatic t_reset;
    check(done == 1'b0, "R6", "done after reset", int'(done), 0);
    check(cfg_err == 1'b0, "R7", "cfg_err after reset", int'(cfg_err), 0);
  endtask

  task automatic t_unarmed;
    run_trace(2, 1'b0, 1, 1, -1, "R1 R2");
    check(done == 1'b0, "R2", "done after unarmed trigger", int'(done), 0);
  endtask

  task automatic t_positive;
    do_arm(N, 3, 2, 3);
    check(cfg_err == 1'b0, "R8", "valid positive accepted", int'(cfg_err), 0);
    check(done == 1'b0, "R6", "done while armed", int'(done), 0);
    run_trace(3, 1'b1, 2, 3, -1, "R3");
    check(done == 1'b1, "R6", "done after pulse", int'(done), 1);
    run_trace(3, 1'b0, 2, 3, -1, "R5");
    check(done == 1'b1, "R5", "done holds after extra trigger", int'(done), 1);
  endtask

  task automatic t_negative_busy_arm;
    do_arm(N, 2, -5, 2);
    check(done == 1'b0, "R6", "arm clears done", int'(done), 0);
    run_trace(2, 1'b1, -5, 2, 8, "R4 R9");
    check(cfg_err == 1'b0, "R9", "busy arm with bad shift ignored", int'(cfg_err), 0);
    check(done == 1'b1, "R4", "done after negative pulse", int'(done), 1);
  endtask

  task automatic t_boundaries;
    do_arm(N, 1, 6, 1);
    check(cfg_err == 1'b0, "R8", "pos limit accepted", int'(cfg_err), 0);
    run_trace(1, 1'b1, 6, 1, -1, "R8 pos limit");
    do_arm(N, 2, -7, 5);
    check(cfg_err == 1'b0, "R8", "neg far limit accepted", int'(cfg_err), 0);
    run_trace(2, 1'b1, -7, 5, -1, "R8 neg far limit");
    do_arm(N, 2, -3, 2);
    check(cfg_err == 1'b0, "R8", "neg near limit accepted", int'(cfg_err), 0);
    run_trace(2, 1'b1, -3, 2, -1, "R8 neg near limit");
  endtask

  task automatic try_bad(input int n, input int d, input int s, input int w, input string what);
    do_arm(n, d, s, w);
    check(cfg_err == 1'b1, "R8", what, int'(cfg_err), 1);
    check(done == 1'b0, "R7", {what, " done"}, int'(done), 0);
  endtask

  task automatic t_invalid;
    try_bad(N, 1, 0, 2, "zero shift");
    try_bad(N, 1, 2, 0, "zero width");
    try_bad(N, 1, 1, N, "width at half period");
    try_bad(N, 1, 6, 2, "positive too far");
    try_bad(N, 2, -2, 2, "negative overlaps edge");
    try_bad(N, 2, -8, 2, "negative too far");
    try_bad(N, 0, 2, 2, "zero delay");
    try_bad(N, 1, -5, 2, "negative with delay one");
    try_bad(3, 1, 1, 1, "half period below four");
    @(negedge clk);
    half_period = NW'(N);
    run_trace(1, 1'b0, 2, 2, -1, "R7");
    check(done == 1'b0, "R7", "done after rejected arm", int'(done), 0);
  endtask

  task automatic t_clear_err;
    do_arm(N, 1, 3, 2);
    check(cfg_err == 1'b0, "R10", "valid arm clears error", int'(cfg_err), 0);
    run_trace(1, 1'b1, 3, 2, -1, "R10 R3");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_positive();
    t_negative_busy_arm();
    t_boundaries();
    t_invalid();
    t_clear_err();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule